// File: doc/BRIEF.md
# Rotary pulse dial generator

This block turns one decimal digit at a time into loop-disconnect pulses on an active-high break output. The break output is the line-switching drive for a telephone dialler. Each digit is sent as a train of timed breaks and makes, and an inter-digit gap follows it. The rate is 10 or 20 pulses per second, and the break/make split is 60:40 or 67:33. Both are selected by configuration inputs. On request the block also issues a single timed hook-flash break, with four selectable lengths. A flash is accepted whether the dialler is in tone or pulse mode.

All timing is counted in ticks of a 1 ms enable input. Two mute outputs are driven alongside the break output. The handset mute covers the pulse train and flash breaks. The line mute covers the whole busy period, inter-digit gap included. The busy flag tells the keypad side when the next digit or flash may be presented.

Top module: `pulse_dialer`

## Requirements
- R1: While reset is asserted and on the first cycles after release, dial_brk, hs_mute, ln_mute and busy are all low.
- R2: A strobed digit code N in 1..9 produces exactly N break pulses, and code 0 produces exactly 10.
- R3: With rate_fast=0, each break lasts 60 ticks and each make 40 ticks when ratio_sel=0; with ratio_sel=1 a break lasts 67 ticks and a make 33 ticks.
- R4: With rate_fast=1, a break lasts 30 ticks and a make 20 ticks when ratio_sel=0; with ratio_sel=1 a break lasts 33 ticks and a make 17 ticks.
- R5: After the make that follows the last break, an 800-tick gap follows. During the gap dial_brk and hs_mute are low and busy stays high.
- R6: busy rises on the cycle after an accepted strobe and stays high until the gap ends. A digit strobe received while busy adds no pulses and does not extend the sequence.
- R7: A flash request while idle yields one break whose length is selected by flash_sel: 0 gives 600 ticks, 1 gives 100, 2 gives 300 and 3 gives 73. No gap follows, and busy falls together with the break.
- R8: With tone_mode=1 a digit strobe is ignored (busy stays low), while a flash request still drives dial_brk.
- R9: hs_mute is high from the accepted strobe through the last make and during a flash break, and low otherwise.
- R10: ln_mute is high exactly while busy is high, during both dialing and flash.
- R11: rate_fast and ratio_sel are captured at the strobe. Changing them while busy has no effect on the digit in progress.
- R12: Digit codes 10..15 are ignored. When a flash request and a digit strobe arrive together while idle, the flash is taken.
- R13: dial_brk changes state only at the end of a tick, apart from its first rise after a strobe or flash request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle enable every millisecond |
| digit_valid | input | 1 | Strobe presenting a digit |
| digit | input | 4 | Digit code, 0..9 valid |
| flash_req | input | 1 | Request for a hook-flash break |
| flash_sel | input | 2 | Flash length select |
| rate_fast | input | 1 | 0: 10 pulses/s, 1: 20 pulses/s |
| ratio_sel | input | 1 | 0: 60:40 break/make, 1: 67:33 |
| tone_mode | input | 1 | 1: digits are not pulsed |
| dial_brk | output | 1 | Active-high line break drive |
| hs_mute | output | 1 | Handset mute |
| ln_mute | output | 1 | Line mute |
| busy | output | 1 | Sequence in progress |

## Verification
The checker covers the output relationships on every cycle. A break always implies both mutes. busy only rises after a strobe or flash request and only falls on a tick. A break ends only on a tick, and a strobe in tone mode never starts a sequence. The lengths of breaks, makes, gaps and flashes need the bench's scenarios. So do the pulse count per digit, the capture of configuration at the strobe, the priority of flash over digit and the ignored strobes; the bench measures these in ticks against values it derives itself.

// File: rtl/pdial_pkg.sv
package pdial_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_BRK   = 3'd1,
    PH_MAKE  = 3'd2,
    PH_GAP   = 3'd3,
    PH_FLASH = 3'd4
  } phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdial_rst_sync.sv
module pdial_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/pdial_timing.sv
module pdial_timing
  import pdial_pkg::*;
#(
  parameter int PERIOD_MS  = 100,
  parameter int BRK_A_MS   = 60,
  parameter int BRK_B_MS   = 67,
  parameter int GAP_MS     = 800,
  parameter int FLASH0_MS  = 600,
  parameter int FLASH1_MS  = 100,
  parameter int FLASH2_MS  = 300,
  parameter int FLASH3_MS  = 73,
  parameter int CNT_W      = 10
) (
  input  phase_t           phase,
  input  logic             fast,
  input  logic             ratio_b,
  input  logic [1:0]       fsel,
  output logic [CNT_W-1:0] limit
);

  localparam int PERIOD_F = PERIOD_MS / 2;
  localparam int BRK_AF   = BRK_A_MS / 2;
  localparam int BRK_BF   = BRK_B_MS / 2;

  logic [CNT_W-1:0] brk_len;
  logic [CNT_W-1:0] per_len;
  logic [CNT_W-1:0] fl_len;

  always_comb begin
    unique case ({fast, ratio_b})
      2'b00:   brk_len = CNT_W'(BRK_A_MS);
      2'b01:   brk_len = CNT_W'(BRK_B_MS);
      2'b10:   brk_len = CNT_W'(BRK_AF);
      default: brk_len = CNT_W'(BRK_BF);
    endcase
    per_len = fast ? CNT_W'(PERIOD_F) : CNT_W'(PERIOD_MS);
    unique case (fsel)
      2'd0:    fl_len = CNT_W'(FLASH0_MS);
      2'd1:    fl_len = CNT_W'(FLASH1_MS);
      2'd2:    fl_len = CNT_W'(FLASH2_MS);
      default: fl_len = CNT_W'(FLASH3_MS);
    endcase
  end

  always_comb begin
    unique case (phase)
      PH_BRK:   limit = brk_len;
      PH_MAKE:  limit = per_len - brk_len;
      PH_GAP:   limit = CNT_W'(GAP_MS);
      PH_FLASH: limit = fl_len;
      default:  limit = CNT_W'(1);
    endcase
  end

endmodule

// File: rtl/pdial_timer.sv
module pdial_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = tick && (cnt_q == limit - CNT_W'(1));
  assign cnt_en = restart || tick;

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pdial_ctrl.sv
module pdial_ctrl
  import pdial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       digit_valid,
  input  logic [3:0] digit,
  input  logic       flash_req,
  input  logic [1:0] flash_sel,
  input  logic       rate_fast,
  input  logic       ratio_sel,
  input  logic       tone_mode,
  input  logic       phase_done,
  output phase_t     phase_q,
  output logic       restart,
  output logic       fast_q,
  output logic       ratio_q,
  output logic [1:0] fsel_q
);

  phase_t     phase_d;
  logic [3:0] left_q, left_d;
  logic       fast_d, ratio_d;
  logic [1:0] fsel_d;
  logic       digit_ok;

  assign digit_ok = digit_valid && !tone_mode && (digit <= 4'd9);

  always_comb begin
    phase_d = phase_q;
    left_d  = left_q;
    fast_d  = fast_q;
    ratio_d = ratio_q;
    fsel_d  = fsel_q;
    restart = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (flash_req) begin
          phase_d = PH_FLASH;
          fsel_d  = flash_sel;
          restart = 1'b1;
        end else if (digit_ok) begin
          phase_d = PH_BRK;
          left_d  = (digit == 4'd0) ? 4'd10 : digit;
          fast_d  = rate_fast;
          ratio_d = ratio_sel;
          restart = 1'b1;
        end
      end
      PH_BRK: begin
        if (phase_done) begin
          phase_d = PH_MAKE;
          restart = 1'b1;
        end
      end
      PH_MAKE: begin
        if (phase_done) begin
          restart = 1'b1;
          if (left_q == 4'd1) begin
            phase_d = PH_GAP;
          end else begin
            phase_d = PH_BRK;
            left_d  = left_q - 4'd1;
          end
        end
      end
      PH_GAP, PH_FLASH: begin
        if (phase_done) begin
          phase_d = PH_IDLE;
          restart = 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        restart = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      fast_q  <= 1'b0;
      ratio_q <= 1'b0;
      fsel_q  <= '0;
    end else begin
      phase_q <= phase_d;
      left_q  <= left_d;
      fast_q  <= fast_d;
      ratio_q <= ratio_d;
      fsel_q  <= fsel_d;
    end
  end

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
  import pdial_pkg::*;
#(
  parameter int PERIOD_MS = 100,
  parameter int BRK_A_MS  = 60,
  parameter int BRK_B_MS  = 67,
  parameter int GAP_MS    = 800,
  parameter int FLASH0_MS = 600,
  parameter int FLASH1_MS = 100,
  parameter int FLASH2_MS = 300,
  parameter int FLASH3_MS = 73
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       digit_valid,
  input  logic [3:0] digit,
  input  logic       flash_req,
  input  logic [1:0] flash_sel,
  input  logic       rate_fast,
  input  logic       ratio_sel,
  input  logic       tone_mode,
  output logic       dial_brk,
  output logic       hs_mute,
  output logic       ln_mute,
  output logic       busy
);

  localparam int LONGEST = max_of(max_of(GAP_MS, PERIOD_MS),
                                  max_of(max_of(FLASH0_MS, FLASH1_MS),
                                         max_of(FLASH2_MS, FLASH3_MS)));
  localparam int CNT_W = $clog2(LONGEST + 1);

  logic             rst_n_i;
  phase_t           phase;
  logic             restart, done;
  logic             fast_q, ratio_q;
  logic [1:0]       fsel_q;
  logic [CNT_W-1:0] limit;

  pdial_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pdial_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .digit_valid (digit_valid),
    .digit       (digit),
    .flash_req   (flash_req),
    .flash_sel   (flash_sel),
    .rate_fast   (rate_fast),
    .ratio_sel   (ratio_sel),
    .tone_mode   (tone_mode),
    .phase_done  (done),
    .phase_q     (phase),
    .restart     (restart),
    .fast_q      (fast_q),
    .ratio_q     (ratio_q),
    .fsel_q      (fsel_q)
  );

  pdial_timing #(
    .PERIOD_MS (PERIOD_MS),
    .BRK_A_MS  (BRK_A_MS),
    .BRK_B_MS  (BRK_B_MS),
    .GAP_MS    (GAP_MS),
    .FLASH0_MS (FLASH0_MS),
    .FLASH1_MS (FLASH1_MS),
    .FLASH2_MS (FLASH2_MS),
    .FLASH3_MS (FLASH3_MS),
    .CNT_W     (CNT_W)
  ) u_timing (
    .phase   (phase),
    .fast    (fast_q),
    .ratio_b (ratio_q),
    .fsel    (fsel_q),
    .limit   (limit)
  );

  pdial_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .tick    (tick_1ms),
    .restart (restart),
    .limit   (limit),
    .done    (done)
  );

  assign dial_brk = (phase == PH_BRK) || (phase == PH_FLASH);
  assign hs_mute  = (phase == PH_BRK) || (phase == PH_MAKE) || (phase == PH_FLASH);
  assign busy     = (phase != PH_IDLE);
  assign ln_mute  = busy;

endmodule

// File: rtl/pulse_dialer_chk.sv
module pulse_dialer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_1ms,
  input logic digit_valid,
  input logic flash_req,
  input logic tone_mode,
  input logic dial_brk,
  input logic hs_mute,
  input logic ln_mute,
  input logic busy
);

  // R9
  brk_mutes_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dial_brk |-> hs_mute);

  // R10
  hs_within_ln_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mute |-> ln_mute);

  // R6
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(digit_valid || flash_req));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_1ms) |=> busy);

  // R13
  brk_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dial_brk) |-> $past(tick_1ms));

  // R8
  tone_no_dial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_mode && !busy && digit_valid && !flash_req) |=> !busy);

endmodule

bind pulse_dialer pulse_dialer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_1ms    (tick_1ms),
  .digit_valid (digit_valid),
  .flash_req   (flash_req),
  .tone_mode   (tone_mode),
  .dial_brk    (dial_brk),
  .hs_mute     (hs_mute),
  .ln_mute     (ln_mute),
  .busy        (busy)
);

// File: tb/pulse_dialer_test.sv
module pulse_dialer_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1ms;
  logic       digit_valid;
  logic [3:0] digit;
  logic       flash_req;
  logic [1:0] flash_sel;
  logic       rate_fast;
  logic       ratio_sel;
  logic       tone_mode;
  logic       dial_brk, hs_mute, ln_mute, busy;

  int nchk = 0;
  int nerr = 0;

  pulse_dialer uut (
    .clk (clk), .rst_n (rst_n), .tick_1ms (tick_1ms),
    .digit_valid (digit_valid), .digit (digit),
    .flash_req (flash_req), .flash_sel (flash_sel),
    .rate_fast (rate_fast), .ratio_sel (ratio_sel), .tone_mode (tone_mode),
    .dial_brk (dial_brk), .hs_mute (hs_mute), .ln_mute (ln_mute), .busy (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    tick_1ms = 1'b0;
    forever begin
      for (int i = 0; i < TICK_DIV; i++) begin
        @(posedge clk);
        #1 tick_1ms = (i == 0);
      end
    end
  end

  function automatic int exp_brk(input bit fast, input bit rb);
    int b = rb ? 67 : 60;
    return fast ? b / 2 : b;
  endfunction

  function automatic int exp_make(input bit fast, input bit rb);
    return (fast ? 50 : 100) - exp_brk(fast, rb);
  endfunction

  function automatic int exp_flash(input logic [1:0] s);
    case (s)
      2'd0: return 600;
      2'd1: return 100;
      2'd2: return 300;
      default: return 73;
    endcase
  endfunction

  function automatic int exp_pulses(input int d);
    return (d == 0) ? 10 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  endtask

  // Dial one digit and measure every phase in ticks.
  task automatic dial(input int d, input bit fast, input bit rb, input bit disturb);
    int brk_run = 0, mk_run = 0, gap_run = 0, pulses = 0, mute_bad = 0;
    bit pb, ph;
    int it = 0;
    rate_fast = fast; ratio_sel = rb;
    @(negedge clk);
    digit = 4'(d); digit_valid = 1'b1;
    @(negedge clk);
    digit_valid = 1'b0;
    chk(busy === 1'b1, "R6 busy after strobe", int'(busy), 1);
    pb = 1'b0; ph = 1'b0;
    while (busy === 1'b1 && it < 20000) begin
      if (dial_brk && !pb) begin
        pulses++;
        if (mk_run > 0) chk(mk_run == exp_make(fast, rb), fast ? "R4 make" : "R3 make", mk_run, exp_make(fast, rb));
        mk_run = 0;
      end
      if (!dial_brk && pb) begin
        chk(brk_run == exp_brk(fast, rb), fast ? "R4 R13 break" : "R3 R13 break", brk_run, exp_brk(fast, rb));
        brk_run = 0;
      end
      if (!hs_mute && ph) begin
        chk(mk_run == exp_make(fast, rb), "R9 last make", mk_run, exp_make(fast, rb));
        mk_run = 0;
      end
      if (ln_mute !== busy) mute_bad++;
      if (tick_1ms) begin
        if (dial_brk)     brk_run++;
        else if (hs_mute) mk_run++;
        else              gap_run++;
      end
      if (disturb && it == 40) begin
        digit = 4'd7; digit_valid = 1'b1;
        rate_fast = ~fast; ratio_sel = ~rb;
      end else begin
        digit_valid = 1'b0;
      end
      pb = dial_brk; ph = hs_mute;
      it++;
      @(negedge clk);
    end
    digit_valid = 1'b0;
    chk(pulses == exp_pulses(d), disturb ? "R6 R11 pulse count" : "R2 pulse count", pulses, exp_pulses(d));
    chk(gap_run == 800, "R5 gap", gap_run, 800);
    chk(mute_bad == 0, "R10 ln_mute", mute_bad, 0);
    rate_fast = fast; ratio_sel = rb;
  endtask

  task automatic flash(input logic [1:0] s, input bit tone, input bit with_digit);
    int run = 0, it = 0, bad = 0;
    tone_mode = tone;
    @(negedge clk);
    flash_sel = s; flash_req = 1'b1;
    if (with_digit) begin digit = 4'd3; digit_valid = 1'b1; end
    @(negedge clk);
    flash_req = 1'b0; digit_valid = 1'b0;
    chk(dial_brk === 1'b1, tone ? "R8 flash in tone" : "R7 flash start", int'(dial_brk), 1);
    while (busy === 1'b1 && it < 20000) begin
      if (tick_1ms && dial_brk) run++;
      if (dial_brk !== busy || hs_mute !== busy || ln_mute !== busy) bad++;
      it++;
      @(negedge clk);
    end
    chk(run == exp_flash(s), with_digit ? "R12 flash priority" : "R7 flash length", run, exp_flash(s));
    chk(bad == 0, "R9 R10 flash mutes", bad, 0);
    tone_mode = 1'b0;
  endtask

  task automatic ignored(input logic [3:0] code, input bit tone, input string req);
    int seen = 0;
    tone_mode = tone;
    @(negedge clk);
    digit = code; digit_valid = 1'b1;
    @(negedge clk);
    digit_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (busy || dial_brk || hs_mute) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, seen, 0);
    tone_mode = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357));
    rst_n = 1'b0; digit_valid = 1'b0; digit = '0; flash_req = 1'b0;
    flash_sel = '0; rate_fast = 1'b0; ratio_sel = 1'b0; tone_mode = 1'b0;
    repeat (4) @(negedge clk);
    chk({dial_brk, hs_mute, ln_mute, busy} == 4'b0, "R1 reset outputs", int'({dial_brk, hs_mute, ln_mute, busy}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({dial_brk, hs_mute, ln_mute, busy} == 4'b0, "R1 after release", int'({dial_brk, hs_mute, ln_mute, busy}), 0);

    dial(0, 1'b0, 1'b0, 1'b0);
    dial(1, 1'b0, 1'b1, 1'b0);
    dial(9, 1'b1, 1'b0, 1'b0);
    dial(4, 1'b1, 1'b1, 1'b0);
    dial(2, 1'b0, 1'b0, 1'b1);
    dial(3, 1'b1, 1'b1, 1'b1);

    for (int s = 0; s < 4; s++) flash(2'(s), 1'b0, 1'b0);
    flash(2'd1, 1'b1, 1'b0);
    flash(2'd3, 1'b0, 1'b1);

    ignored(4'd5, 1'b1, "R8 tone digit ignored");
    ignored(4'd10, 1'b0, "R12 code 10 ignored");
    ignored(4'd15, 1'b0, "R12 code 15 ignored");

    for (int k = 0; k < 6; k++) begin
      int d = int'($urandom % 10);
      bit f = 1'($urandom);
      bit r = 1'($urandom);
      dial(d, f, r, 1'($urandom % 4 == 0));
    end

    finish_run();
  end

endmodule